// File: doc/BRIEF.md
# Comma-Aligned Deserializer with Complementary Byte Clocks

This block sits behind a bit-rate sampler. It shifts a retimed serial stream, one bit per clock, into a word window and emits ten-bit parallel words. Two byte-clock outputs run in antiphase at half the word rate. Consecutive words are handed out on alternate byte clocks, so each clock owns every second word.

The block watches the window for the positive-disparity comma. A comma that does not fall on the current word boundary moves the boundary to it. The move only delays the next word and the next byte-clock edge, so no clock level ever comes out short. After a realignment, the next word is steered to the second byte clock. Commas that open later four-word ordered sets then appear on the rising edge of the first byte clock. A short holdoff after each realignment stops a nearby comma from pulling the boundary a second time.

Top module: `comma_deser`

## Requirements
- R1: Within each output word, bit i is the i-th bit received for that word, so the first bit received lands in bit 0. A word appears on `word_out` at the clock edge after the edge that sampled its last bit.
- R2: While `rst` is high, `word_out` is 0, `byte_clk_a` is 0 and `byte_clk_b` is 1. After release, the first word boundary falls ten edges later.
- R3: `byte_clk_b` is always the complement of `byte_clk_a`. In steady operation with no realignment, each level of `byte_clk_a` lasts exactly WORD_W clock cycles.
- R4: Output words alternate between the two byte clocks. The owning clock rises WORD_W/2 edges after its word is placed on `word_out`, and that word holds for at least WORD_W/2 cycles after the rise.
- R5: A comma is seen when window bits [6:0] equal 7'b1111100. Bit 0 is the first of the ten bits received, so the received order is 0,0,1,1,1,1,1. Window bits 9 to 7 are ignored.
- R6: A comma that already falls on the current word boundary leaves the word timing and byte-clock timing unchanged, and the comma is output as a normal word.
- R7: A comma off the current boundary moves the boundary so that the next word starts with the first bit after the comma. The partial word and the comma itself are not output. No byte-clock level is ever shorter than WORD_W cycles.
- R8: After a realignment, the next word goes to `byte_clk_b`. A comma that opens a four-word ordered set after the realigning comma is therefore on `word_out` when `byte_clk_a` rises.
- R9: A misaligned comma detected within WORD_W cycles after a realignment is ignored. The boundary set by the first comma is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Retimed serial data, one bit per clock |
| word_out | output | 10 | Recovered parallel word |
| byte_clk_a | output | 1 | Byte clock owning the words aligned to commas |
| byte_clk_b | output | 1 | Antiphase byte clock owning the other words |

## Verification
A bit sampled at edge k belongs to a word that completes at some edge k'. That word reaches `word_out` at edge k'+1, and its byte clock moves five edges after that. A realignment decided at edge k places the next word on `word_out` at edge k+10. The bench feeds every bit on a falling edge and advances its behavioural model on the same rising edges as the design. It compares outputs at each falling edge, so every result is checked in the cycle it is due. The bench tracks bit positions itself to place commas on or off the boundary, and it measures level lengths and word-to-edge spacing against these latencies.

// File: rtl/cd_pkg.sv
package cd_pkg;
  // action chosen by the framing controller for one bit period
  typedef enum logic [1:0] {
    ACT_COUNT   = 2'd0,
    ACT_WRAP    = 2'd1,
    ACT_REALIGN = 2'd2
  } frame_act_t;

  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cd_window.sv
module cd_window #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  output logic [WORD_W-1:0] win
);
  // newest bit enters at the top, oldest sits in bit 0
  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else     win <= {ser_in, win[WORD_W-1:1]};
  end
endmodule

// File: rtl/cd_mark_find.sv
module cd_mark_find #(
  parameter int              WORD_W   = 10,
  parameter int              MARK_LEN = 7,
  parameter logic [MARK_LEN-1:0] MARK_PAT = 7'b1111100
) (
  input  logic [WORD_W-1:0] win,
  output logic              hit
);
  logic [MARK_LEN-1:0] bit_ok;

  for (genvar i = 0; i < MARK_LEN; i++) begin : g_cmp
    assign bit_ok[i] = (win[i] == MARK_PAT[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/cd_frame_ctrl.sv
module cd_frame_ctrl
  import cd_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic wrap,
  output logic realign,
  output logic sel
);
  localparam int PW = cnt_width(WORD_W);
  localparam logic [PW-1:0] LAST = PW'(WORD_W - 1);

  logic [PW-1:0] ph;
  logic          guard;
  frame_act_t    act;

  always_comb begin
    act = ACT_COUNT;
    if (hit && (ph != LAST) && !guard) act = ACT_REALIGN;
    else if (ph == LAST)               act = ACT_WRAP;
  end

  assign wrap    = (act == ACT_WRAP);
  assign realign = (act == ACT_REALIGN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      guard <= 1'b0;
      sel   <= 1'b1;
    end else begin
      unique case (act)
        ACT_REALIGN: begin
          ph    <= '0;
          guard <= 1'b1;
          sel   <= 1'b0;
        end
        ACT_WRAP: begin
          ph    <= '0;
          guard <= 1'b0;
          sel   <= ~sel;
        end
        default: ph <= ph + PW'(1);
      endcase
    end
  end
endmodule

// File: rtl/cd_byteclk.sv
module cd_byteclk #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  logic              sel,
  input  logic [WORD_W-1:0] win,
  output logic [WORD_W-1:0] word_out,
  output logic              byte_clk_a,
  output logic              byte_clk_b
);
  localparam int HALF = WORD_W / 2;
  localparam int HW   = $clog2(HALF + 1);
  localparam logic [HW-1:0] HALF_C = HW'(HALF);

  logic          owner;
  logic [HW-1:0] hc;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out   <= '0;
      owner      <= 1'b0;
      hc         <= '0;
      byte_clk_a <= 1'b0;
      byte_clk_b <= 1'b1;
    end else if (wrap) begin
      word_out <= win;
      owner    <= sel;
      hc       <= HALF_C;
    end else if (hc != '0) begin
      hc <= hc - HW'(1);
      if (hc == HW'(1)) begin
        byte_clk_a <= owner;
        byte_clk_b <= ~owner;
      end
    end
  end
endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int                  WORD_W   = 10,
  parameter int                  MARK_LEN = 7,
  parameter logic [MARK_LEN-1:0] MARK_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  output logic [WORD_W-1:0] word_out,
  output logic              byte_clk_a,
  output logic              byte_clk_b
);
  logic [WORD_W-1:0] win;
  logic              hit;
  logic              wrap;
  logic              realign;
  logic              sel;

  cd_window #(.WORD_W(WORD_W)) u_win (
    .clk(clk), .rst(rst), .ser_in(ser_in), .win(win)
  );

  cd_mark_find #(.WORD_W(WORD_W), .MARK_LEN(MARK_LEN), .MARK_PAT(MARK_PAT)) u_find (
    .win(win), .hit(hit)
  );

  cd_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .hit(hit), .wrap(wrap), .realign(realign), .sel(sel)
  );

  cd_byteclk #(.WORD_W(WORD_W)) u_bclk (
    .clk(clk), .rst(rst), .wrap(wrap), .sel(sel), .win(win),
    .word_out(word_out), .byte_clk_a(byte_clk_a), .byte_clk_b(byte_clk_b)
  );
endmodule

// File: rtl/cd_chk.sv
module cd_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] word_out,
  input logic              byte_clk_a,
  input logic              byte_clk_b,
  input logic              realign
);
  localparam int HALF = WORD_W / 2;
  localparam int CW   = $clog2(2 * WORD_W + 1) + 1;
  localparam logic [CW-1:0] CMAX = CW'(2 * WORD_W);

  logic              a_q, b_q;
  logic [WORD_W-1:0] w_q;
  logic [CW-1:0]     lvl_age, dout_age, rise_age, gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= 1'b0;
      b_q      <= 1'b1;
      w_q      <= '0;
      lvl_age  <= '0;
      dout_age <= '0;
      rise_age <= CMAX;
      gap      <= CMAX;
    end else begin
      a_q <= byte_clk_a;
      b_q <= byte_clk_b;
      w_q <= word_out;
      if (byte_clk_a != a_q)    lvl_age <= CW'(1);
      else if (lvl_age != CMAX) lvl_age <= lvl_age + CW'(1);
      if (word_out != w_q)       dout_age <= CW'(1);
      else if (dout_age != CMAX) dout_age <= dout_age + CW'(1);
      if ((byte_clk_a && !a_q) || (byte_clk_b && !b_q)) rise_age <= CW'(1);
      else if (rise_age != CMAX)                        rise_age <= rise_age + CW'(1);
      if (realign)           gap <= CW'(1);
      else if (gap != CMAX)  gap <= gap + CW'(1);
    end
  end

  // R3
  byteclk_antiphase_chk: assert property (@(posedge clk) disable iff (rst)
    byte_clk_a != byte_clk_b);

  // R7
  min_level_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_clk_a != a_q) |-> (lvl_age >= CW'(WORD_W)));

  // R4
  word_setup_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(byte_clk_a) || $rose(byte_clk_b)) |-> (dout_age >= CW'(HALF)));

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word_out != w_q) |-> (rise_age >= CW'(WORD_W - HALF)));

  // R9
  realign_gap_chk: assert property (@(posedge clk) disable iff (rst)
    realign |-> (gap >= CW'(WORD_W)));
endmodule

bind comma_deser cd_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .word_out(word_out),
  .byte_clk_a(byte_clk_a), .byte_clk_b(byte_clk_b), .realign(realign)
);

// File: tb/comma_deser_test.sv
module comma_deser_test;
  localparam int W    = 10;
  localparam int HALF = W / 2;
  localparam logic [9:0] D1 = 10'h2C5, D2 = 10'h0F0, D3 = 10'h133;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic [9:0] word_out;
  logic       byte_clk_a, byte_clk_b;

  always #2 clk = ~clk;

  comma_deser uut (
    .clk(clk), .rst(rst), .ser_in(ser_in),
    .word_out(word_out), .byte_clk_a(byte_clk_a), .byte_clk_b(byte_clk_b)
  );

  int    checks = 0, errors = 0;
  string req = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         hq[$];
  int         pos, tcyc;
  bit         guard, nsel, mb1;
  logic [9:0] mdout;
  int         ev_t[$];
  bit         ev_v[$];

  function automatic bit comma_in_hist();
    return hq[0] == 0 && hq[1] == 0 && hq[2] && hq[3] && hq[4] && hq[5] && hq[6];
  endfunction

  function automatic logic [9:0] hist_word();
    logic [9:0] w;
    for (int i = 0; i < W; i++) w[i] = hq[i];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hq.delete();
      for (int i = 0; i < W; i++) hq.push_back(1'b0);
      pos = 0; guard = 0; nsel = 1; mb1 = 0; mdout = '0; tcyc = 0;
      ev_t.delete(); ev_v.delete();
    end else begin
      if (ev_t.size() > 0 && ev_t[0] == tcyc) begin
        mb1 = ev_v[0];
        void'(ev_t.pop_front());
        void'(ev_v.pop_front());
      end
      if (comma_in_hist() && pos != W - 1 && !guard) begin
        pos = 0; guard = 1; nsel = 0;
      end else if (pos == W - 1) begin
        mdout = hist_word();
        ev_t.push_back(tcyc + HALF);
        ev_v.push_back(nsel);
        nsel = !nsel; pos = 0; guard = 0;
      end else begin
        pos++;
      end
      hq.push_back(ser_in);
      void'(hq.pop_front());
      tcyc++;
    end
  end

  // ---------------- per-cycle compare and monitors ----------------
  int  ncyc = 0, last_chg = 0, last_dchg = 0;
  bit  a_prev = 0, b_prev = 1;
  logic [9:0] d_prev = '0;
  bit  exact_mode = 0;
  int  exact_skip = 0;
  bit  stretch_seen = 0;
  int  a_comma = 0, b_comma = 0;
  logic [9:0] watch_word = '0;
  bit  watch_seen = 0;

  always @(negedge clk) begin
    if (!rst) begin
      ncyc++;
      chk(word_out == mdout, req, "word_out", int'(word_out), int'(mdout));
      chk(byte_clk_a == mb1, req, "byte_clk_a", int'(byte_clk_a), int'(mb1));
      chk(byte_clk_b == !mb1, req, "byte_clk_b", int'(byte_clk_b), int'(!mb1));
      if (word_out != d_prev) last_dchg = ncyc;
      if (word_out == watch_word) watch_seen = 1;
      if (byte_clk_a != a_prev) begin
        // R7: no level shorter than a word
        chk((ncyc - last_chg) >= W, "R7", "level length", ncyc - last_chg, W);
        if (ncyc - last_chg > W) stretch_seen = 1;
        if (exact_mode) begin
          if (exact_skip > 0) exact_skip--;
          else chk((ncyc - last_chg) == W, req, "steady level length", ncyc - last_chg, W);
        end
        last_chg = ncyc;
      end
      if ((byte_clk_a && !a_prev) || (byte_clk_b && !b_prev)) begin
        // R4: word placed HALF cycles before its clock rises
        chk((ncyc - last_dchg) >= HALF, "R4", "word age at rise", ncyc - last_dchg, HALF);
        if (word_out[6:0] == 7'b1111100) begin
          if (byte_clk_a) a_comma++;
          else b_comma++;
        end
      end
      a_prev = byte_clk_a; b_prev = byte_clk_b; d_prev = word_out;
    end
  end

  // ---------------- stimulus ----------------
  int bitno = 0;
  int align_mod = 0;
  bit idle_v = 0;

  task automatic put_bit(input bit b);
    @(negedge clk);
    ser_in = b;
    bitno++;
  endtask

  task automatic put_idle(input int n);
    for (int i = 0; i < n; i++) begin
      put_bit(idle_v);
      idle_v = !idle_v;
    end
  endtask

  task automatic put_word(input logic [9:0] w);
    for (int i = 0; i < W; i++) put_bit(w[i]);
  endtask

  task automatic pad_to(input int off);
    int target;
    target = (align_mod + off) % W;
    while (((bitno + 1) % W) != target) put_idle(1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    chk(word_out == 10'h000, "R2", "reset word_out", int'(word_out), 0);
    chk(byte_clk_a == 1'b0, "R2", "reset byte_clk_a", int'(byte_clk_a), 0);
    chk(byte_clk_b == 1'b1, "R2", "reset byte_clk_b", int'(byte_clk_b), 1);
    rst = 1'b0;
    ser_in = 1'b0;
    bitno = 0;
    align_mod = 0;

    // R3: steady idle, levels exactly one word long
    req = "R3"; exact_mode = 1; exact_skip = 2;
    put_idle(200);
    exact_mode = 0;

    // R5 / R7 / R8 / R1: misaligned comma with nonzero tail bits, then ordered sets
    req = "R7"; stretch_seen = 0; a_comma = 0; b_comma = 0;
    watch_word = D1; watch_seen = 0;
    pad_to(3);
    align_mod = (bitno + 1) % W;
    put_word(10'h37C);
    put_word(D1); put_word(D2); put_word(D3);
    for (int k = 0; k < 2; k++) begin
      put_word(10'h17C); put_word(D1); put_word(D2); put_word(D3);
    end
    put_idle(60);
    chk(stretch_seen, "R7", "stretched level seen", int'(stretch_seen), 1);
    chk(a_comma == 2, "R8", "commas on byte_clk_a rises", a_comma, 2);
    chk(b_comma == 0, "R8", "commas on byte_clk_b rises", b_comma, 0);
    chk(watch_seen, "R1", "data word recovered in bit order", int'(watch_seen), 1);
    chk(watch_seen, "R5", "comma with tail 3'b011 realigned", int'(watch_seen), 1);

    // R6: commas already on the boundary
    req = "R6"; exact_mode = 1; exact_skip = 1;
    watch_word = 10'h17C; watch_seen = 0;
    pad_to(0);
    for (int k = 0; k < 2; k++) begin
      put_word(10'h17C); put_word(D1); put_word(10'h17C); put_word(D3);
    end
    put_idle(60);
    exact_mode = 0;
    chk(watch_seen, "R6", "aligned comma passed through", int'(watch_seen), 1);

    // R9: a second comma inside the holdoff is ignored
    req = "R9"; watch_word = 10'h00F; watch_seen = 0;
    pad_to(4);
    align_mod = (bitno + 1) % W;
    put_word(10'h27C);
    put_word(10'h00F);
    put_word(D2);
    put_idle(60);
    chk(watch_seen, "R9", "word after first comma kept", int'(watch_seen), 1);

    req = "R4";
    put_idle(40);
    finish_run();
  end
endmodule